// File: doc/BRIEF.md
# Three-Agent Ownership Semaphore

This block arbitrates exclusive use of a shared management bus and a non-volatile memory port among three agents: software, a manageability controller and the chip's own hardware. Each agent has its own ownership bit. It drives a write strobe with a data bit and reads its bit back. To ask for ownership, an agent writes 1 and then polls. Ownership is held only while the bit reads 1. To hand the resource back, the owner writes 0. The block itself does not stop a non-owner from touching the bus. Agents are expected to follow the protocol. The internal hardware agent does so, for example while it loads extended configuration data.

The software and hardware bits live in the ordinary reset domain. They are tracked by a three-state controller with the states FREE, SW_HELD and HW_HELD:

- FREE goes to SW_HELD on a granted software request.
- FREE goes to HW_HELD on a granted hardware request.
- SW_HELD goes back to FREE when software writes 0.
- HW_HELD goes back to FREE when hardware writes 0.

The manageability bit sits in a separate flop that only the power-good reset clears. An ordinary reset therefore never takes ownership away from the manageability controller. A 2-bit owner code gives downstream logic a compact view of who currently holds the resource.

Top module: `sema_owner_reg`

## Requirements
- R1: A write of 1 by an agent while all three ownership bits are 0 sets that agent's bit. The read data shows 1 on the first clock edge after the write is sampled, and 0 before it.
- R2: A write of 1 while a different agent's bit is 1 leaves the written bit at 0. This holds even if the current owner releases in the same cycle.
- R3: At no time are two or more of the three ownership bits 1 together.
- R4: When several agents write 1 in the same cycle and all bits are 0, only one request is granted. Manageability wins over software, and software wins over hardware.
- R5: When the owning agent writes 0, its bit clears on the next edge, and the resource is free for the following cycle's requests.
- R6: A write of 0 to a bit that is 0 changes no bit. A write of 1 to a bit already at 1 keeps it at 1. With no write strobe, every bit holds its value.
- R7: Asserting the ordinary reset (rst_n low, asynchronous) clears the software and hardware bits and leaves the manageability bit unchanged.
- R8: Asserting the power-good reset (pwrgood_rst_n low, asynchronous) clears the manageability bit and leaves the software and hardware bits unchanged.
- R9: owner_code reads 2'b00 when no bit is set, 2'b01 for software, 2'b10 for manageability and 2'b11 for hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; clears the software and hardware bits |
| pwrgood_rst_n | input | 1 | Power-good reset, active low, asynchronous; clears the manageability bit |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 1 | Software write value (1 request, 0 release) |
| sw_rd_data | output | 1 | Software ownership bit |
| mng_wr_en | input | 1 | Manageability write strobe |
| mng_wr_data | input | 1 | Manageability write value |
| mng_rd_data | output | 1 | Manageability ownership bit |
| hw_wr_en | input | 1 | Hardware write strobe |
| hw_wr_data | input | 1 | Hardware write value |
| hw_rd_data | output | 1 | Hardware ownership bit |
| owner_code | output | 2 | Current owner: 00 none, 01 software, 10 manageability, 11 hardware |

## Verification
The bound checker watches these properties on every clock edge:

- the three bits are never set together (at most one bit is 1);
- a request made while another agent holds the bit is refused;
- manageability wins a simultaneous request;
- a release clears the bit;
- an idle owner keeps its bit;
- the owner code agrees with the bits;
- the manageability bit keeps its value across an ordinary reset.

Some behaviour only the bench scenarios can show:

- the exact cycle in which a grant first becomes visible;
- the full priority chain when software and hardware contend without manageability;
- a release and a request in the same cycle;
- the power-good reset leaving a hardware owner in place.

// File: rtl/sema_pkg.sv
package sema_pkg;

    // Owner code seen by downstream monitors
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_SW   = 2'b01,
        OWN_MNG  = 2'b10,
        OWN_HW   = 2'b11
    } owner_code_e;

    // States of the ordinary-reset-domain ownership controller
    typedef enum logic [1:0] {
        ST_FREE    = 2'b00,
        ST_SW_HELD = 2'b01,
        ST_HW_HELD = 2'b10
    } core_state_e;

    // One agent's write port
    typedef struct packed {
        logic en;
        logic data;
    } agent_wr_t;

endpackage

// File: rtl/sema_grant_logic.sv
module sema_grant_logic
    import sema_pkg::*;
(
    input  logic      mng_q,
    input  logic      sw_q,
    input  logic      hw_q,
    input  agent_wr_t mng_wr,
    input  agent_wr_t sw_wr,
    input  agent_wr_t hw_wr,
    output logic      mng_set,
    output logic      mng_clr,
    output logic      sw_set,
    output logic      sw_clr,
    output logic      hw_set,
    output logic      hw_clr
);

    logic all_free;
    logic mng_req;
    logic sw_req;
    logic hw_req;

    always_comb begin
        all_free = !mng_q && !sw_q && !hw_q;
        mng_req  = mng_wr.en && mng_wr.data;
        sw_req   = sw_wr.en  && sw_wr.data;
        hw_req   = hw_wr.en  && hw_wr.data;

        // Grants only out of the free condition, fixed priority mng > sw > hw
        mng_set  = all_free && mng_req;
        sw_set   = all_free && sw_req && !mng_req;
        hw_set   = all_free && hw_req && !mng_req && !sw_req;

        // Release only by the owner writing 0
        mng_clr  = mng_q && mng_wr.en && !mng_wr.data;
        sw_clr   = sw_q  && sw_wr.en  && !sw_wr.data;
        hw_clr   = hw_q  && hw_wr.en  && !hw_wr.data;
    end

endmodule

// File: rtl/sema_mng_bit.sv
module sema_mng_bit (
    input  logic clk,
    input  logic pwrgood_rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic held_q;

    always_ff @(posedge clk or negedge pwrgood_rst_n) begin
        if (!pwrgood_rst_n) begin
            held_q <= 1'b0;
        end else if (set_i) begin
            held_q <= 1'b1;
        end else if (clr_i) begin
            held_q <= 1'b0;
        end
    end

    assign q_o = held_q;

endmodule

// File: rtl/sema_core_fsm.sv
module sema_core_fsm
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    input  logic hw_clr,
    output logic sw_q,
    output logic hw_q
);

    core_state_e state_q;
    core_state_e state_d;

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (sw_set) begin
                    state_d = ST_SW_HELD;
                end else if (hw_set) begin
                    state_d = ST_HW_HELD;
                end
            end
            ST_SW_HELD: begin
                if (sw_clr) begin
                    state_d = ST_FREE;
                end
            end
            ST_HW_HELD: begin
                if (hw_clr) begin
                    state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        sw_q = 1'b0;
        hw_q = 1'b0;
        unique case (state_q)
            ST_FREE:    ;
            ST_SW_HELD: sw_q = 1'b1;
            ST_HW_HELD: hw_q = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/sema_owner_reg.sv
module sema_owner_reg
    import sema_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrgood_rst_n,
    input  logic       sw_wr_en,
    input  logic       sw_wr_data,
    output logic       sw_rd_data,
    input  logic       mng_wr_en,
    input  logic       mng_wr_data,
    output logic       mng_rd_data,
    input  logic       hw_wr_en,
    input  logic       hw_wr_data,
    output logic       hw_rd_data,
    output logic [1:0] owner_code
);

    agent_wr_t   sw_wr;
    agent_wr_t   mng_wr;
    agent_wr_t   hw_wr;
    logic        mng_q;
    logic        sw_q;
    logic        hw_q;
    logic        mng_set;
    logic        mng_clr;
    logic        sw_set;
    logic        sw_clr;
    logic        hw_set;
    logic        hw_clr;
    owner_code_e code;

    assign sw_wr  = '{en: sw_wr_en,  data: sw_wr_data};
    assign mng_wr = '{en: mng_wr_en, data: mng_wr_data};
    assign hw_wr  = '{en: hw_wr_en,  data: hw_wr_data};

    sema_grant_logic u_grant (
        .mng_q   (mng_q),
        .sw_q    (sw_q),
        .hw_q    (hw_q),
        .mng_wr  (mng_wr),
        .sw_wr   (sw_wr),
        .hw_wr   (hw_wr),
        .mng_set (mng_set),
        .mng_clr (mng_clr),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .hw_set  (hw_set),
        .hw_clr  (hw_clr)
    );

    // Manageability bit: power-good domain only
    sema_mng_bit u_mng (
        .clk           (clk),
        .pwrgood_rst_n (pwrgood_rst_n),
        .set_i         (mng_set),
        .clr_i         (mng_clr),
        .q_o           (mng_q)
    );

    // Software / hardware bits: ordinary reset domain
    sema_core_fsm u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .hw_set (hw_set),
        .hw_clr (hw_clr),
        .sw_q   (sw_q),
        .hw_q   (hw_q)
    );

    always_comb begin
        unique case ({mng_q, sw_q, hw_q})
            3'b100:  code = OWN_MNG;
            3'b010:  code = OWN_SW;
            3'b001:  code = OWN_HW;
            default: code = OWN_NONE;
        endcase
    end

    assign sw_rd_data  = sw_q;
    assign mng_rd_data = mng_q;
    assign hw_rd_data  = hw_q;
    assign owner_code  = code;

endmodule

// File: rtl/sema_owner_reg_checker.sv
module sema_owner_reg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pwrgood_rst_n,
    input logic       sw_wr_en,
    input logic       sw_wr_data,
    input logic       sw_rd_data,
    input logic       mng_wr_en,
    input logic       mng_wr_data,
    input logic       mng_rd_data,
    input logic       hw_wr_en,
    input logic       hw_wr_data,
    input logic       hw_rd_data,
    input logic [1:0] owner_code
);

    logic both_rst;
    assign both_rst = rst_n && pwrgood_rst_n;

    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!both_rst)
        $onehot0({mng_rd_data, sw_rd_data, hw_rd_data})); // R3

    AST_SW_BLOCKED: assert property (@(posedge clk) disable iff (!both_rst)
        (mng_rd_data && sw_wr_en && sw_wr_data) |=> !sw_rd_data); // R2

    AST_HW_BLOCKED: assert property (@(posedge clk) disable iff (!both_rst)
        (sw_rd_data && hw_wr_en && hw_wr_data) |=> !hw_rd_data); // R2

    AST_MNG_FIRST: assert property (@(posedge clk) disable iff (!both_rst)
        (!mng_rd_data && !sw_rd_data && !hw_rd_data && mng_wr_en && mng_wr_data
         && sw_wr_en && sw_wr_data) |=> (mng_rd_data && !sw_rd_data)); // R4

    AST_SW_RELEASE: assert property (@(posedge clk) disable iff (!both_rst)
        (sw_rd_data && sw_wr_en && !sw_wr_data) |=> !sw_rd_data); // R5

    AST_SW_HOLD: assert property (@(posedge clk) disable iff (!both_rst)
        (sw_rd_data && !sw_wr_en) |=> sw_rd_data); // R6

    AST_MNG_KEEP: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (mng_rd_data && !mng_wr_en) |=> mng_rd_data); // R7

    AST_ORD_RST_CLEAR: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        !rst_n |-> (!sw_rd_data && !hw_rd_data)); // R7

    AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!both_rst)
        (owner_code == {mng_rd_data | hw_rd_data, sw_rd_data | hw_rd_data})); // R9

endmodule

bind sema_owner_reg sema_owner_reg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrgood_rst_n (pwrgood_rst_n),
    .sw_wr_en      (sw_wr_en),
    .sw_wr_data    (sw_wr_data),
    .sw_rd_data    (sw_rd_data),
    .mng_wr_en     (mng_wr_en),
    .mng_wr_data   (mng_wr_data),
    .mng_rd_data   (mng_rd_data),
    .hw_wr_en      (hw_wr_en),
    .hw_wr_data    (hw_wr_data),
    .hw_rd_data    (hw_rd_data),
    .owner_code    (owner_code)
);

// File: tb/sema_owner_reg_bench.sv
module sema_owner_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 16;
    localparam int WATCHDOG   = 5000;

    // Row: {mng_en, mng_d, sw_en, sw_d, hw_en, hw_d, exp_mng, exp_sw, exp_hw}
    localparam logic [8:0] VEC [NROWS] = '{
        9'b000000_000, // idle, nothing owned                          R6
        9'b001100_010, // sw requests from free                        R1
        9'b000011_010, // hw requests while sw owns: refused           R2
        9'b111000_000, // sw releases, mng requests same cycle: refused R2 R5
        9'b111111_100, // all request together: mng wins               R4
        9'b001111_100, // sw and hw request under mng: refused         R2
        9'b000010_100, // hw writes 0 to unowned bit: no effect        R6
        9'b110000_100, // mng rewrites 1: stays set                    R6
        9'b100000_000, // mng releases                                 R5
        9'b001111_010, // sw and hw together: sw wins                  R4
        9'b001000_000, // sw releases                                  R5
        9'b000011_001, // hw requests from free                        R1
        9'b110000_001, // mng requests while hw owns: refused          R2
        9'b000010_000, // hw releases                                  R5
        9'b100011_001, // mng writes 0 (not owner), hw requests        R6
        9'b000010_000  // hw releases                                  R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrgood_rst_n = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic       sw_wr_data = 1'b0;
    logic       mng_wr_en = 1'b0;
    logic       mng_wr_data = 1'b0;
    logic       hw_wr_en = 1'b0;
    logic       hw_wr_data = 1'b0;
    logic       sw_rd_data;
    logic       mng_rd_data;
    logic       hw_rd_data;
    logic [1:0] owner_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sema_owner_reg u_sema_owner_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwrgood_rst_n (pwrgood_rst_n),
        .sw_wr_en      (sw_wr_en),
        .sw_wr_data    (sw_wr_data),
        .sw_rd_data    (sw_rd_data),
        .mng_wr_en     (mng_wr_en),
        .mng_wr_data   (mng_wr_data),
        .mng_rd_data   (mng_rd_data),
        .hw_wr_en      (hw_wr_en),
        .hw_wr_data    (hw_wr_data),
        .hw_rd_data    (hw_rd_data),
        .owner_code    (owner_code)
    );

    function automatic logic [1:0] exp_code(input logic [2:0] bits);
        case (bits)
            3'b100:  return 2'b10;
            3'b010:  return 2'b01;
            3'b001:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // Compares {mng, sw, hw} bits and owner code against expectation
    task automatic check(input string req, input logic [2:0] exp_bits);
        logic [2:0] act;
        act = {mng_rd_data, sw_rd_data, hw_rd_data};
        checks++;
        if (act !== exp_bits) begin
            errors++;
            $display("FAIL %s bits {mng,sw,hw}: actual %b expected %b", req, act, exp_bits);
        end
        checks++;
        if (owner_code !== exp_code(exp_bits)) begin
            errors++;
            $display("FAIL %s/R9 owner_code: actual %b expected %b", req, owner_code,
                     exp_code(exp_bits));
        end
    endtask

    task automatic drive(input logic [5:0] w);
        {mng_wr_en, mng_wr_data, sw_wr_en, sw_wr_data, hw_wr_en, hw_wr_data} = w;
    endtask

    // Drive one write set at a falling edge, sample after the next rising edge
    task automatic step(input logic [5:0] w);
        drive(w);
        @(posedge clk);
        @(negedge clk);
        drive(6'b0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state: R7 R8
        check("R7 reset", 3'b000);
        rst_n = 1'b1;
        pwrgood_rst_n = 1'b1;
        @(negedge clk);
        check("R7 after reset", 3'b000);

        // R1: grant not visible before the edge, visible after it
        drive(6'b001100);
        #1;
        check("R1 before edge", 3'b000);
        @(posedge clk);
        @(negedge clk);
        drive(6'b0);
        check("R1 after edge", 3'b010);
        step(6'b001000);
        check("R5 release", 3'b000);

        // Table walk: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NROWS; i++) begin
            step(VEC[i][8:3]);
            check($sformatf("R1/R2/R3/R4/R5/R6 row %0d", i), VEC[i][2:0]);
        end

        // R7: ordinary reset keeps mng owner
        step(6'b110000);
        check("R1 mng acquire", 3'b100);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mng survives reset", 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 mng after reset", 3'b100);

        // R8: power-good reset clears mng
        pwrgood_rst_n = 1'b0;
        @(negedge clk);
        check("R8 mng cleared", 3'b000);
        pwrgood_rst_n = 1'b1;
        @(negedge clk);

        // R7: ordinary reset clears sw owner
        step(6'b001100);
        check("R1 sw acquire", 3'b010);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 sw cleared", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: power-good reset leaves hw owner in place
        step(6'b000011);
        check("R1 hw acquire", 3'b001);
        pwrgood_rst_n = 1'b0;
        @(negedge clk);
        check("R8 hw survives pwrgood reset", 3'b001);
        pwrgood_rst_n = 1'b1;
        @(negedge clk);
        step(6'b000000);
        check("R6 hw holds idle", 3'b001);
        step(6'b000010);
        check("R5 hw release", 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule